// File: doc/BRIEF.md
# Column Vector Double Buffer

This block holds the two intermediate vectors, called here the scale vector `c` and the gain vector `a`, that a forward elimination pipeline produces for a group of j-columns. It also hands them to a backward substitution pipeline. Storage is split into two banks, and each bank holds one memory per vector. While the forward side fills one bank, the backward side reads the other. When the forward side signals that a group is finished, the banks swap roles, so the two pipelines can run in parallel on neighbouring groups.

Each bank holds `NSLOT` column slots of `NJ` entries for each vector, which is 44 slots of 16 entries by default. An entry at slot `s` and index `j` is stored at word address `s*NJ + j`, and reads use the same address. The write port is a valid/ready stream. A word pair is taken on a clock edge only when `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the producer must hold its data and wait. The read port has no back-pressure. A request on `rd_req` always returns a response one cycle later, and the requester must take it then. The block does no arithmetic.

The read side reports that it has finished with its bank by pulsing `rd_done`. If the forward side finishes a group before that happens, the swap is held back. The block raises `stall` and drops `wr_ready` until `rd_done` arrives.

Top module: `pp_colvec_buf`

## Requirements
- R1: Straight after reset, `wr_bank` is 0, `stall` is 0, `wr_ready` is 1 and `rd_valid` is 0.
- R2: When `wr_valid` and `wr_ready` are both high on an edge and `wr_slot < NSLOT`, `wr_c` and `wr_a` are stored at address `wr_slot*NJ + wr_j` of the bank selected by `wr_bank`. A write with `wr_slot >= NSLOT` leaves every stored entry unchanged.
- R3: A request on `rd_req` gives `rd_valid` high on the next cycle, with `rd_c` and `rd_a` holding both words at address `rd_slot*NJ + rd_j` of the bank not selected by `wr_bank` at the time of the request. Without a request, `rd_valid` is low on the next cycle.
- R4: `rd_ok` is high only together with `rd_valid`. It is low if the read bank has not yet been filled and handed over by a swap, or if `rd_slot >= NSLOT`. Whenever `rd_ok` is low, `rd_c` and `rd_a` are 0.
- R5: A `grp_done` pulse arriving while the read side has no group outstanding swaps the banks on that edge. `wr_bank` toggles, `stall` stays 0, and the bank that was just written becomes readable.
- R6: A `grp_done` pulse arriving while a handed-over group has not yet been released by `rd_done` sets `stall` to 1 and `wr_ready` to 0 from the next cycle. Both hold until `rd_done`. That `rd_done` performs the swap, and `stall` falls on the following cycle.
- R7: An `rd_done` pulse arriving while no group is outstanding is ignored. `wr_bank`, `stall` and the readable bank's contents do not change.
- R8: Writes into the write bank never change what reads return from the read bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word pair offered |
| wr_ready | output | 1 | Write port can accept |
| wr_slot | input | SLOT_W | Column slot of the write |
| wr_j | input | J_W | j index of the write |
| wr_c | input | DATA_W | Scale-vector word to store |
| wr_a | input | DATA_W | Gain-vector word to store |
| rd_req | input | 1 | Read request |
| rd_slot | input | SLOT_W | Column slot to read |
| rd_j | input | J_W | j index to read |
| rd_valid | output | 1 | Read response present |
| rd_ok | output | 1 | Response data is from a filled bank and a valid slot |
| rd_c | output | DATA_W | Scale-vector word read |
| rd_a | output | DATA_W | Gain-vector word read |
| grp_done | input | 1 | Forward side finished a group; request a swap |
| rd_done | input | 1 | Backward side finished its group |
| stall | output | 1 | Swap held back until the read side finishes |
| wr_bank | output | 1 | Bank currently in the write role |

## Verification
On every cycle the assertions check the read timing and the zeroing of rejected responses. They also check that `stall` rises only after a blocked `grp_done`, that it holds until `rd_done` and then clears, and that `wr_bank` moves only on a swap request. Only the bench's scenarios can show the stored contents. These include data landing at `slot*NJ + j`, banks keeping separate contents across swaps, out-of-range writes being dropped, a write held off during a stall, and a stray `rd_done` leaving the readable data alone.

// File: rtl/pp_colvec_pkg.sv
package pp_colvec_pkg;
  // read-side occupancy of the handed-over bank
  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,  // no group outstanding on the read side
    RS_BUSY = 2'd1,  // a group was handed over and is being consumed
    RS_PEND = 2'd2   // writer finished another group; swap waiting
  } rd_state_e;
endpackage

// File: rtl/pp_dpram.sv
module pp_dpram #(
  parameter int W     = 32,
  parameter int DEPTH = 704,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pp_swap_ctrl.sv
module pp_swap_ctrl
  import pp_colvec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grp_done,
  input  logic       rd_done,
  output logic       wr_bank,
  output logic [1:0] filled,
  output logic       stall
);
  rd_state_e state, state_n;
  logic      do_swap;

  always_comb begin
    state_n = state;
    do_swap = 1'b0;
    unique case (state)
      RS_IDLE: if (grp_done) begin
        do_swap = 1'b1;
        state_n = RS_BUSY;
      end
      RS_BUSY: begin
        if (grp_done && rd_done) begin
          do_swap = 1'b1;
          state_n = RS_BUSY;
        end else if (grp_done) begin
          state_n = RS_PEND;
        end else if (rd_done) begin
          state_n = RS_IDLE;
        end
      end
      RS_PEND: if (rd_done) begin
        do_swap = 1'b1;
        state_n = RS_BUSY;
      end
      default: state_n = RS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= RS_IDLE;
      wr_bank <= 1'b0;
      filled  <= 2'b00;
    end else begin
      state <= state_n;
      if (do_swap) begin
        wr_bank           <= ~wr_bank;
        filled[wr_bank]   <= 1'b1;
        filled[~wr_bank]  <= 1'b0;
      end
    end
  end

  assign stall = (state == RS_PEND);
endmodule

// File: rtl/pp_colvec_buf.sv
module pp_colvec_buf #(
  parameter int DATA_W  = 32,
  parameter int NSLOT   = 44,
  parameter int NJ      = 16,
  localparam int SLOT_W = $clog2(NSLOT),
  localparam int J_W    = $clog2(NJ)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [J_W-1:0]    wr_j,
  input  logic [DATA_W-1:0] wr_c,
  input  logic [DATA_W-1:0] wr_a,
  input  logic              rd_req,
  input  logic [SLOT_W-1:0] rd_slot,
  input  logic [J_W-1:0]    rd_j,
  output logic              rd_valid,
  output logic              rd_ok,
  output logic [DATA_W-1:0] rd_c,
  output logic [DATA_W-1:0] rd_a,
  input  logic              grp_done,
  input  logic              rd_done,
  output logic              stall,
  output logic              wr_bank
);
  localparam int DEPTH = NSLOT * NJ;
  localparam int AW    = $clog2(DEPTH);

  logic [1:0]        filled;
  logic              wr_in_rng, rd_in_rng, wr_fire;
  logic [AW-1:0]     waddr, raddr;
  logic              sel_q, ok_q, vld_q;
  logic [DATA_W-1:0] qc [2];
  logic [DATA_W-1:0] qa [2];

  pp_swap_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .grp_done (grp_done),
    .rd_done  (rd_done),
    .wr_bank  (wr_bank),
    .filled   (filled),
    .stall    (stall)
  );

  assign wr_ready  = ~stall;
  assign wr_in_rng = int'(wr_slot) < NSLOT;
  assign rd_in_rng = int'(rd_slot) < NSLOT;
  assign wr_fire   = wr_valid & wr_ready & wr_in_rng;
  assign waddr     = wr_in_rng ? AW'(wr_slot) * AW'(NJ) + AW'(wr_j) : '0;
  assign raddr     = rd_in_rng ? AW'(rd_slot) * AW'(NJ) + AW'(rd_j) : '0;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic we_b;
    assign we_b = wr_fire & (wr_bank == 1'(b));
    pp_dpram #(.W(DATA_W), .DEPTH(DEPTH)) u_cmem (
      .clk (clk), .we (we_b), .waddr (waddr), .wdata (wr_c),
      .raddr (raddr), .rdata (qc[b])
    );
    pp_dpram #(.W(DATA_W), .DEPTH(DEPTH)) u_amem (
      .clk (clk), .we (we_b), .waddr (waddr), .wdata (wr_a),
      .raddr (raddr), .rdata (qa[b])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      ok_q  <= 1'b0;
      sel_q <= 1'b0;
    end else begin
      vld_q <= rd_req;
      ok_q  <= rd_req & rd_in_rng & filled[~wr_bank];
      sel_q <= ~wr_bank;
    end
  end

  assign rd_valid = vld_q;
  assign rd_ok    = ok_q;
  assign rd_c     = ok_q ? qc[sel_q] : '0;
  assign rd_a     = ok_q ? qa[sel_q] : '0;
endmodule

// File: rtl/pp_colvec_buf_chk.sv
module pp_colvec_buf_chk #(
  parameter int DATA_W = 32,
  parameter int NSLOT  = 44,
  parameter int SLOT_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic [SLOT_W-1:0] rd_slot,
  input logic              rd_valid,
  input logic              rd_ok,
  input logic [DATA_W-1:0] rd_c,
  input logic [DATA_W-1:0] rd_a,
  input logic              grp_done,
  input logic              rd_done,
  input logic              stall,
  input logic              wr_bank
);
  p_rd_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_valid);
  p_rd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_valid);
  p_ok_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |-> rd_valid);
  p_zero_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_ok |-> (rd_c == '0 && rd_a == '0));
  p_slot_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && int'(rd_slot) >= NSLOT) |=> !rd_ok);
  p_stall_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> ($past(grp_done) && !$past(rd_done)));
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !rd_done) |=> stall);
  p_stall_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && rd_done) |=> !stall);
  p_bank_move_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_bank != $past(wr_bank)) |-> $past(grp_done || stall));
endmodule

bind pp_colvec_buf pp_colvec_buf_chk #(
  .DATA_W (DATA_W), .NSLOT (NSLOT), .SLOT_W (SLOT_W)
) u_chk (
  .clk (clk), .rst_n (rst_n), .rd_req (rd_req), .rd_slot (rd_slot),
  .rd_valid (rd_valid), .rd_ok (rd_ok), .rd_c (rd_c), .rd_a (rd_a),
  .grp_done (grp_done), .rd_done (rd_done), .stall (stall),
  .wr_bank (wr_bank)
);

// File: tb/pp_colvec_buf_tb.sv
`timescale 1ns/1ps
module pp_colvec_buf_tb;
  localparam int NT = 8;
  // stimulus vectors {slot[5:0], j[3:0]}; expected words derived from them
  localparam logic [9:0] TAB [NT] = '{
    {6'd0, 4'd0}, {6'd0, 4'd15}, {6'd1, 4'd0}, {6'd7, 4'd9},
    {6'd21, 4'd4}, {6'd42, 4'd15}, {6'd43, 4'd0}, {6'd43, 4'd15}
  };

  logic        clk = 0, rst_n = 0;
  logic        wr_valid = 0, rd_req = 0, grp_done = 0, rd_done = 0;
  logic [5:0]  wr_slot = 0, rd_slot = 0;
  logic [3:0]  wr_j = 0, rd_j = 0;
  logic [31:0] wr_c = 0, wr_a = 0;
  logic        wr_ready, rd_valid, rd_ok, stall, wr_bank;
  logic [31:0] rd_c, rd_a;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #2 clk = ~clk;

  pp_colvec_buf u_dut (
    .clk (clk), .rst_n (rst_n), .wr_valid (wr_valid), .wr_ready (wr_ready),
    .wr_slot (wr_slot), .wr_j (wr_j), .wr_c (wr_c), .wr_a (wr_a),
    .rd_req (rd_req), .rd_slot (rd_slot), .rd_j (rd_j),
    .rd_valid (rd_valid), .rd_ok (rd_ok), .rd_c (rd_c), .rd_a (rd_a),
    .grp_done (grp_done), .rd_done (rd_done), .stall (stall),
    .wr_bank (wr_bank)
  );

  function automatic logic [31:0] cval(logic [5:0] s, logic [3:0] j, int g);
    return 32'hC000_0000 ^ (32'(g) << 20) ^ (32'(s) << 8) ^ 32'(j);
  endfunction
  function automatic logic [31:0] aval(logic [5:0] s, logic [3:0] j, int g);
    return 32'hA000_0000 ^ (32'(g) << 20) ^ (32'(j) << 12) ^ 32'(s);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] s, input logic [3:0] j,
                    input logic [31:0] c, input logic [31:0] a);
    @(negedge clk);
    wr_valid = 1; wr_slot = s; wr_j = j; wr_c = c; wr_a = a;
    chk(wr_ready == 1'b1, "R2 ready", 32'(wr_ready), 32'd1);
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic rd(input logic [5:0] s, input logic [3:0] j, input bit eok,
                    input logic [31:0] ec, input logic [31:0] ea, input string req);
    @(negedge clk);
    rd_req = 1; rd_slot = s; rd_j = j;
    @(negedge clk);
    rd_req = 0;
    chk(rd_valid == 1'b1, req, 32'(rd_valid), 32'd1);
    chk(rd_ok == eok, req, 32'(rd_ok), 32'(eok));
    chk(rd_c == ec, req, rd_c, ec);
    chk(rd_a == ea, req, rd_a, ea);
  endtask

  task automatic pulse_grp();
    @(negedge clk); grp_done = 1;
    @(negedge clk); grp_done = 0;
  endtask

  task automatic pulse_rdd();
    @(negedge clk); rd_done = 1;
    @(negedge clk); rd_done = 0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(wr_bank == 0, "R1 wr_bank", 32'(wr_bank), 0);
    chk(stall == 0, "R1 stall", 32'(stall), 0);
    chk(wr_ready == 1, "R1 wr_ready", 32'(wr_ready), 1);
    chk(rd_valid == 0, "R1 rd_valid", 32'(rd_valid), 0);
    // R4 no bank handed over yet
    rd(6'd0, 4'd0, 0, 0, 0, "R4 unfilled");

    // R2 fill bank 0 with group 1 from the table
    for (int i = 0; i < NT; i++)
      wr(TAB[i][9:4], TAB[i][3:0], cval(TAB[i][9:4], TAB[i][3:0], 1),
         aval(TAB[i][9:4], TAB[i][3:0], 1));
    wr(6'd44, 4'd0, 32'hDEAD_0001, 32'hDEAD_0002);  // R2 out of range
    wr(6'd63, 4'd15, 32'hDEAD_0003, 32'hDEAD_0004);

    // R5 swap with read side idle
    pulse_grp();
    chk(wr_bank == 1, "R5 toggle", 32'(wr_bank), 1);
    chk(stall == 0, "R5 no stall", 32'(stall), 0);

    // R3 read back group 1 from bank 0
    for (int i = 0; i < NT; i++)
      rd(TAB[i][9:4], TAB[i][3:0], 1, cval(TAB[i][9:4], TAB[i][3:0], 1),
         aval(TAB[i][9:4], TAB[i][3:0], 1), "R3 readback");
    rd(6'd44, 4'd0, 0, 0, 0, "R4 slot range");
    rd(6'd0, 4'd0, 1, cval(0, 0, 1), aval(0, 0, 1), "R2 dropped write");

    // R8 write group 2 into bank 1, bank 0 reads unchanged
    for (int i = 0; i < NT; i++)
      wr(TAB[i][9:4], TAB[i][3:0], cval(TAB[i][9:4], TAB[i][3:0], 2),
         aval(TAB[i][9:4], TAB[i][3:0], 2));
    rd(TAB[5][9:4], TAB[5][3:0], 1, cval(TAB[5][9:4], TAB[5][3:0], 1),
       aval(TAB[5][9:4], TAB[5][3:0], 1), "R8 isolation");

    // R6 swap request while read group outstanding
    pulse_grp();
    chk(stall == 1, "R6 stall set", 32'(stall), 1);
    chk(wr_ready == 0, "R6 ready low", 32'(wr_ready), 0);
    chk(wr_bank == 1, "R6 held bank", 32'(wr_bank), 1);
    @(negedge clk);
    wr_valid = 1; wr_slot = 0; wr_j = 0; wr_c = 32'hBAD0_BAD0; wr_a = 32'hBAD1_BAD1;
    repeat (3) @(negedge clk);
    wr_valid = 0;
    chk(stall == 1, "R6 stall hold", 32'(stall), 1);
    pulse_rdd();
    chk(stall == 0, "R6 released", 32'(stall), 0);
    chk(wr_bank == 0, "R6 swapped", 32'(wr_bank), 0);
    for (int i = 0; i < NT; i++)
      rd(TAB[i][9:4], TAB[i][3:0], 1, cval(TAB[i][9:4], TAB[i][3:0], 2),
         aval(TAB[i][9:4], TAB[i][3:0], 2), "R6 group2");

    // R7 stray rd_done while idle
    pulse_rdd();
    pulse_rdd();
    chk(wr_bank == 0, "R7 bank kept", 32'(wr_bank), 0);
    chk(stall == 0, "R7 no stall", 32'(stall), 0);
    rd(TAB[3][9:4], TAB[3][3:0], 1, cval(TAB[3][9:4], TAB[3][3:0], 2),
       aval(TAB[3][9:4], TAB[3][3:0], 2), "R7 data kept");
    pulse_grp();
    chk(wr_bank == 1, "R5 idle swap", 32'(wr_bank), 1);
    chk(stall == 0, "R5 idle swap stall", 32'(stall), 0);
    rd(TAB[7][9:4], TAB[7][3:0], 1, cval(TAB[7][9:4], TAB[7][3:0], 1),
       aval(TAB[7][9:4], TAB[7][3:0], 1), "R8 bank0 kept");

    @(negedge clk);
    chk(rd_valid == 0, "R3 no request", 32'(rd_valid), 0);
    summary();
  end
endmodule